// File: doc/BRIEF.md
# SPI Master Timing Sequencer

This block is a serial peripheral master that runs one 8-bit transfer at a time to one of a small set of slaves, each selected by its own active-low select line. Every slave has its own timing profile, held in a configuration bank: a serial clock divisor, a lead delay from select assertion to the first clock edge, and a trail delay that follows every transfer while the select stays asserted. A single shared swap delay separates the release of one select from the assertion of a different one. Because each profile is looked up by the request's select index, moving between slaves of different speeds needs no reprogramming.

A request carries a data byte and a select index. The block shifts the byte out most significant bit first in mode 0: the clock idles low, output data changes on the falling clock edge and input data is sampled on the rising edge. When the eighth bit has been clocked, the received byte is presented with a one-cycle done strobe. After the trail delay the select remains asserted, so a following request to the same slave keeps the select low throughout, while a request to another slave first releases it and waits out the swap delay. A divisor of zero is illegal; a request aimed at a slave whose divisor is still zero is refused with a one-cycle error pulse and starts nothing.

Top module: `spim_seq`

## Requirements
- R1: After reset all selects are high (cs_n all ones), sck and mosi are 0, busy, done and err are 0, req_ready is 1, rx_data is 0 and every divisor, lead, trail and swap setting is 0.
- R2: A request while req_ready is 1 to a select whose divisor is 0 is refused: err is 1 for exactly the next cycle, busy stays 0, cs_n and sck do not change and no transfer follows.
- R3: During a transfer each high and each low phase of sck lasts exactly divisor system clock cycles, eight rising edges occur, and sck is 0 whenever all selects are high.
- R4: The request byte leaves on mosi most significant bit first; mosi takes bit 7 in the cycle after acceptance and changes otherwise only on falling sck edges, never on a rising one.
- R5: mosi-side data is mirrored by miso sampling on each rising sck edge, first sample into bit 7; the assembled byte appears on rx_data in the cycle done is 1.
- R6: For a newly asserted select, the select is low for lead+1 cycles plus one divisor half-period before the first rising sck edge.
- R7: The done cycle and the following trail cycles keep the select low and req_ready at 0 for trail+1 cycles in total, after which req_ready returns to 1.
- R8: A request to the same select as the previous transfer keeps that select low without release between the two transfers.
- R9: A request to a different select releases the held select; all selects are high for exactly swap+1 cycles before the new select goes low.
- R10: Each select uses its own divisor, lead and trail; two selects with different divisors produce different sck periods without any reprogramming in between.
- R11: busy rises in the cycle after acceptance and falls in the cycle done is 1; done is a single-cycle pulse and req_ready is 0 while busy is 1.
- R12: At most one select line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the per-select timing profile |
| cfg_sel | input | CS_W | Select index whose profile is written |
| cfg_div | input | CNT_W | Serial clock divisor, 1 to 255 |
| cfg_lead | input | CNT_W | Lead delay count |
| cfg_trail | input | CNT_W | Trail delay count |
| cfg_swap_we | input | 1 | Write the shared swap delay |
| cfg_swap_dly | input | CNT_W | Swap delay count |
| req_valid | input | 1 | Transfer request |
| req_sel | input | CS_W | Target select index |
| req_data | input | DW | Byte to send |
| req_ready | output | 1 | Block can take a request this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rx_data | output | DW | Received byte |
| err | output | 1 | One-cycle refusal pulse for a zero divisor |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low select lines |

## Verification
A wrong delay or divisor count inside the block shows at the ports as a select edge or an sck edge one or more cycles off the expected place, visible during the first transfer that uses the faulty profile. A fault in the shift path shows on mosi at the first rising sck edge and on rx_data in the done cycle. A fault in the sequencing state shows as two selects low together, sck moving with all selects high, a select released between same-slave transfers, or a refused request that still starts; each of these appears in the cycle it happens because every output is compared against a cycle-level reference on every clock.

// File: rtl/spim_seq_pkg.sv
package spim_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SWAP  = 3'd1,
    ST_LEAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_TRAIL = 3'd4,
    ST_PARK  = 3'd5
  } spim_state_e;

endpackage

// File: rtl/spim_seq_cfg.sv
module spim_seq_cfg #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 8,
  parameter int CS_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CS_W-1:0]  wr_sel,
  input  logic [CNT_W-1:0] wr_div,
  input  logic [CNT_W-1:0] wr_lead,
  input  logic [CNT_W-1:0] wr_trail,
  input  logic             swap_we,
  input  logic [CNT_W-1:0] swap_in,
  input  logic [CS_W-1:0]  rd_sel,
  output logic [CNT_W-1:0] rd_div,
  output logic [CNT_W-1:0] rd_lead,
  output logic [CNT_W-1:0] rd_trail,
  output logic [CNT_W-1:0] swap_dly
);

  logic [CNT_W-1:0] div_q   [NUM_CS];
  logic [CNT_W-1:0] lead_q  [NUM_CS];
  logic [CNT_W-1:0] trail_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        div_q[g]   <= '0;
        lead_q[g]  <= '0;
        trail_q[g] <= '0;
      end else if (wr_en && (wr_sel == CS_W'(g))) begin
        div_q[g]   <= wr_div;
        lead_q[g]  <= wr_lead;
        trail_q[g] <= wr_trail;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swap_dly <= '0;
    end else if (swap_we) begin
      swap_dly <= swap_in;
    end
  end

  assign rd_div   = div_q[rd_sel];
  assign rd_lead  = lead_q[rd_sel];
  assign rd_trail = trail_q[rd_sel];

endmodule

// File: rtl/spim_seq_shift.sv
module spim_seq_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rise,
  input  logic          fall,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_word
);

  logic [DW-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
    end else begin
      if (load) begin
        mosi <= load_data[DW-1];
        tx_q <= {load_data[DW-2:0], 1'b0};
      end else if (fall) begin
        mosi <= tx_q[DW-1];
        tx_q <= {tx_q[DW-2:0], 1'b0};
      end
      if (rise) begin
        rx_word <= {rx_word[DW-2:0], miso};
      end
    end
  end

endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DW     = 8,
  parameter int CNT_W  = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic [CNT_W-1:0]  cfg_div,
  input  logic [CNT_W-1:0]  cfg_lead,
  input  logic [CNT_W-1:0]  cfg_trail,
  input  logic              cfg_swap_we,
  input  logic [CNT_W-1:0]  cfg_swap_dly,
  input  logic              req_valid,
  input  logic [CS_W-1:0]   req_sel,
  input  logic [DW-1:0]     req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rx_data,
  output logic              err,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int HALF_W = $clog2(2 * DW);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * DW - 1);
  localparam logic [NUM_CS-1:0] CS_NONE = '1;

  spim_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_div_q;
  logic [CNT_W-1:0] cur_lead_q;
  logic [CNT_W-1:0] cur_trail_q;
  logic [HALF_W-1:0] half_q;
  logic [CS_W-1:0]  cur_sel_q;
  logic             sck_q;

  logic [CNT_W-1:0] rd_div;
  logic [CNT_W-1:0] rd_lead;
  logic [CNT_W-1:0] rd_trail;
  logic [CNT_W-1:0] swap_dly;
  logic [DW-1:0]    rx_word;

  logic accept;
  logic refuse;
  logic tick;
  logic rise;
  logic fall;
  logic last_fall;

  function automatic logic [NUM_CS-1:0] sel_mask(input logic [CS_W-1:0] s);
    sel_mask = ~(NUM_CS'(1) << s);
  endfunction

  spim_seq_cfg #(
    .NUM_CS (NUM_CS),
    .CNT_W  (CNT_W),
    .CS_W   (CS_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_div   (cfg_div),
    .wr_lead  (cfg_lead),
    .wr_trail (cfg_trail),
    .swap_we  (cfg_swap_we),
    .swap_in  (cfg_swap_dly),
    .rd_sel   (req_sel),
    .rd_div   (rd_div),
    .rd_lead  (rd_lead),
    .rd_trail (rd_trail),
    .swap_dly (swap_dly)
  );

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_PARK);
  assign accept    = req_ready && req_valid && (rd_div != '0);
  assign refuse    = req_ready && req_valid && (rd_div == '0);
  assign tick      = (st_q == ST_SHIFT) && (cnt_q == '0);
  assign rise      = tick && !sck_q;
  assign fall      = tick && sck_q;
  assign last_fall = fall && (half_q == HALF_LAST);
  assign sck       = sck_q;

  spim_seq_shift #(
    .DW (DW)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (req_data),
    .rise      (rise),
    .fall      (fall),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      cur_div_q   <= '0;
      cur_lead_q  <= '0;
      cur_trail_q <= '0;
      cur_sel_q   <= '0;
      half_q      <= '0;
      sck_q       <= 1'b0;
      cs_n        <= CS_NONE;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      rx_data     <= '0;
    end else begin
      done <= 1'b0;
      err  <= refuse;
      unique case (st_q)
        ST_IDLE, ST_PARK: begin
          if (accept) begin
            busy        <= 1'b1;
            cur_sel_q   <= req_sel;
            cur_div_q   <= rd_div;
            cur_lead_q  <= rd_lead;
            cur_trail_q <= rd_trail;
            if ((st_q == ST_PARK) && (req_sel != cur_sel_q)) begin
              cs_n  <= CS_NONE;
              st_q  <= ST_SWAP;
              cnt_q <= swap_dly;
            end else begin
              cs_n  <= sel_mask(req_sel);
              st_q  <= ST_LEAD;
              cnt_q <= rd_lead;
            end
          end
        end
        ST_SWAP: begin
          if (cnt_q == '0) begin
            cs_n  <= sel_mask(cur_sel_q);
            st_q  <= ST_LEAD;
            cnt_q <= cur_lead_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            st_q   <= ST_SHIFT;
            cnt_q  <= cur_div_q - CNT_W'(1);
            half_q <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            cnt_q  <= cur_div_q - CNT_W'(1);
            half_q <= half_q + HALF_W'(1);
            if (last_fall) begin
              done    <= 1'b1;
              busy    <= 1'b0;
              rx_data <= rx_word;
              st_q    <= ST_TRAIL;
              cnt_q   <= cur_trail_q;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_TRAIL: begin
          if (cnt_q == '0) begin
            st_q <= ST_PARK;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/spim_seq_chk.sv
module spim_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              mosi,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              req_ready
);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1); // R12

  AST_SCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    sck |-> (cs_n != '1)); // R3

  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && $stable(cs_n) && !sck)); // R2

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !busy); // R11

  AST_MOSI_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi)); // R4

  AST_DONE_SELECT_HELD: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n != '1)); // R7

endmodule

bind spim_seq spim_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sck       (sck),
  .mosi      (mosi),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .req_ready (req_ready)
);

// File: tb/spim_seq_bench.sv
`timescale 1ns/1ps
module spim_seq_bench;

  localparam int NCS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_div = '0;
  logic [7:0] cfg_lead = '0;
  logic [7:0] cfg_trail = '0;
  logic       cfg_swap_we = 1'b0;
  logic [7:0] cfg_swap_dly = '0;
  logic       req_valid = 1'b0;
  logic [1:0] req_sel = '0;
  logic [7:0] req_data = '0;
  logic       req_ready, busy, done, err, sck, mosi, miso;
  logic [7:0] rx_data;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  spim_seq u_spim_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_div(cfg_div),
    .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_swap_we(cfg_swap_we),
    .cfg_swap_dly(cfg_swap_dly), .req_valid(req_valid), .req_sel(req_sel),
    .req_data(req_data), .req_ready(req_ready), .busy(busy), .done(done),
    .rx_data(rx_data), .err(err), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Slave: presents bit 7 first, advances after each rising sck seen.
  logic [7:0] slave_byte = 8'h00;
  int bitcnt = 0;
  assign miso = (bitcnt < 8) ? slave_byte[7 - bitcnt] : 1'b0;

  // Reference model, phases: 0 idle, 1 swap, 2 lead, 3 shift, 4 trail, 5 park
  int m_div [NCS];
  int m_lead [NCS];
  int m_trail [NCS];
  int m_swap, m_ph, m_t, m_cur, m_kdiv, m_klead, m_ktrail, m_falls;
  logic [7:0] m_tx, m_rx;
  logic [3:0] e_cs_n;
  logic e_sck, e_mosi, e_busy, e_done, e_err;
  logic [7:0] e_rx;
  bit m_live = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      end_run();
    end
    if (rst) begin
      for (int i = 0; i < NCS; i++) begin
        m_div[i] = 0; m_lead[i] = 0; m_trail[i] = 0;
      end
      m_swap = 0; m_ph = 0; m_t = 0; m_cur = 0; m_falls = 0;
      m_kdiv = 0; m_klead = 0; m_ktrail = 0; m_tx = 0; m_rx = 0;
      e_cs_n = 4'hF; e_sck = 0; e_mosi = 0; e_busy = 0; e_done = 0; e_err = 0; e_rx = 0;
      m_live = 1;
    end else begin
      e_done = 0;
      e_err = 0;
      if ((m_ph == 0 || m_ph == 5) && req_valid) begin
        if (m_div[req_sel] == 0) begin
          e_err = 1;
        end else begin
          e_busy = 1;
          m_kdiv = m_div[req_sel]; m_klead = m_lead[req_sel]; m_ktrail = m_trail[req_sel];
          m_tx = req_data; e_mosi = req_data[7]; m_falls = 0;
          if (m_ph == 5 && int'(req_sel) != m_cur) begin
            e_cs_n = 4'hF; m_ph = 1; m_t = m_swap;
          end else begin
            e_cs_n = ~(4'b1 << req_sel); m_ph = 2; m_t = m_klead;
          end
          m_cur = req_sel;
        end
      end else begin
        case (m_ph)
          1: if (m_t == 0) begin e_cs_n = ~(4'b1 << m_cur); m_ph = 2; m_t = m_klead; end
             else m_t--;
          2: if (m_t == 0) begin m_ph = 3; m_t = m_kdiv - 1; end
             else m_t--;
          3: if (m_t == 0) begin
               m_t = m_kdiv - 1;
               if (!e_sck) begin
                 e_sck = 1; m_rx = {m_rx[6:0], miso};
               end else begin
                 e_sck = 0; m_falls++;
                 e_mosi = (m_falls < 8) ? m_tx[7 - m_falls] : 1'b0;
                 if (m_falls == 8) begin
                   e_done = 1; e_busy = 0; e_rx = m_rx; m_ph = 4; m_t = m_ktrail;
                 end
               end
             end else m_t--;
          4: if (m_t == 0) m_ph = 5;
             else m_t--;
          default: ;
        endcase
      end
      if (cfg_we) begin
        m_div[cfg_sel] = cfg_div; m_lead[cfg_sel] = cfg_lead; m_trail[cfg_sel] = cfg_trail;
      end
      if (cfg_swap_we) m_swap = cfg_swap_dly;
    end
  end

  // Per-cycle comparison and port monitors
  logic prev_sck = 0;
  logic [3:0] prev_cs = 4'hF;
  logic [7:0] mosi_word = 0;
  int since_rise = 0, per_meas = 0;
  int lead_cnt = 0, lead_meas = 0;
  bit lead_done = 0;
  int high_run = 0, swap_meas = 0;
  int tr_cnt = 0, trail_meas = 0;
  bit tr_on = 0;
  bit cs_rose = 0;
  int multi_sel = 0;

  always @(negedge clk) begin
    if (!rst && m_live) begin
      chk(cs_n == e_cs_n, "R9 cs_n", cs_n, e_cs_n);
      chk(sck == e_sck, "R3 sck", sck, e_sck);
      chk(mosi == e_mosi, "R4 mosi", mosi, e_mosi);
      chk(busy == e_busy, "R11 busy", busy, e_busy);
      chk(done == e_done, "R11 done", done, e_done);
      chk(err == e_err, "R2 err", err, e_err);
      chk(req_ready == (m_ph == 0 || m_ph == 5), "R7 req_ready", req_ready, (m_ph == 0 || m_ph == 5));
      chk(rx_data == e_rx, "R5 rx_data", rx_data, e_rx);

      if ($countones(~cs_n) > 1) multi_sel++;
      if (sck && !prev_sck) begin
        mosi_word = {mosi_word[6:0], mosi};
        per_meas = since_rise; since_rise = 1;
        bitcnt = bitcnt + 1;
      end else since_rise++;
      if (done) bitcnt = 0;

      if (cs_n == 4'hF) begin
        lead_cnt = 0; lead_done = 0; high_run++;
      end else begin
        if (prev_cs == 4'hF) begin swap_meas = high_run; high_run = 0; end
        if (!lead_done) begin
          if (sck) begin lead_meas = lead_cnt; lead_done = 1; end
          else lead_cnt++;
        end
      end
      if (prev_cs != 4'hF && cs_n == 4'hF) cs_rose = 1;

      if (done) begin tr_cnt = 1; tr_on = 1; end
      else if (tr_on) begin
        if (req_ready) begin trail_meas = tr_cnt; tr_on = 0; end
        else tr_cnt++;
      end
      prev_sck = sck;
      prev_cs = cs_n;
    end
  end

  task automatic cfg_slot(input int s, input int dv, input int ld, input int tr);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 2'(s); cfg_div = 8'(dv); cfg_lead = 8'(ld); cfg_trail = 8'(tr);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic cfg_swap(input int d);
    @(posedge clk); #1;
    cfg_swap_we = 1; cfg_swap_dly = 8'(d);
    @(posedge clk); #1;
    cfg_swap_we = 0;
  endtask

  task automatic send(input int s, input logic [7:0] d, input logic [7:0] sb);
    do begin @(posedge clk); #1; end while (!req_ready);
    slave_byte = sb;
    req_valid = 1; req_sel = 2'(s); req_data = d;
    @(posedge clk); #1;
    req_valid = 0;
    chk(busy == 1, "R11 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    chk(rx_data == sb, "R5 received byte", rx_data, sb);
    chk(mosi_word == d, "R4 sent byte msb first", mosi_word, d);
    chk(busy == 0, "R11 busy clear at done", busy, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bad(input int s, input logic [3:0] cs_exp);
    do begin @(posedge clk); #1; end while (!req_ready);
    req_valid = 1; req_sel = 2'(s); req_data = 8'hC9;
    @(posedge clk); #1;
    req_valid = 0;
    chk(err == 1, "R2 err pulse", err, 1);
    chk(busy == 0, "R2 no busy", busy, 0);
    chk(cs_n == cs_exp, "R2 selects unchanged", cs_n, cs_exp);
    @(posedge clk); #1;
    chk(err == 0, "R2 err single cycle", err, 0);
    repeat (6) @(posedge clk);
    #1;
    chk(sck == 0 && busy == 0, "R2 no transfer started", {sck, busy}, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(cs_n == 4'hF, "R1 selects high", cs_n, 4'hF);
    chk(sck == 0 && mosi == 0, "R1 sck mosi low", {sck, mosi}, 0);
    chk(busy == 0 && done == 0 && err == 0, "R1 flags low", {busy, done, err}, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);

    send_bad(0, 4'hF);  // R1 divisors reset to zero, R2 refusal

    cfg_swap(3);
    cfg_slot(0, 1, 0, 0);
    cfg_slot(1, 3, 2, 4);
    cfg_slot(2, 2, 5, 1);

    send(0, 8'hA5, 8'h3C);
    chk(lead_meas == 2, "R6 lead cs0", lead_meas, 2);
    chk(per_meas == 2, "R3 period cs0", per_meas, 2);
    chk(trail_meas == 1, "R7 trail cs0", trail_meas, 1);

    cs_rose = 0;
    send(0, 8'h5A, 8'hC3);
    chk(cs_rose == 0, "R8 select held same slave", cs_rose, 0);

    send(1, 8'hFF, 8'h00);
    chk(swap_meas == 4, "R9 swap gap", swap_meas, 4);
    chk(lead_meas == 6, "R6 lead cs1", lead_meas, 6);
    chk(per_meas == 6, "R10 period cs1 own divisor", per_meas, 6);
    chk(trail_meas == 5, "R7 trail cs1", trail_meas, 5);

    send(1, 8'h00, 8'hFF);
    send(2, 8'h81, 8'h7E);
    chk(swap_meas == 4, "R9 swap gap cs2", swap_meas, 4);
    chk(lead_meas == 8, "R6 lead cs2", lead_meas, 8);
    chk(per_meas == 4, "R3 period cs2", per_meas, 4);
    chk(trail_meas == 2, "R7 trail cs2", trail_meas, 2);

    send_bad(3, 4'b1011);

    cfg_slot(0, 255, 0, 3);
    send(0, 8'h96, 8'h69);
    chk(per_meas == 510, "R10 period cs0 slowest", per_meas, 510);
    chk(lead_meas == 256, "R6 lead cs0 slow", lead_meas, 256);
    chk(trail_meas == 4, "R7 trail cs0 slow", trail_meas, 4);

    chk(multi_sel == 0, "R12 single select", multi_sel, 0);
    end_run();
  end

endmodule